// File: doc/BRIEF.md
# Instruction-Framed Serial Register Port

This block is a serial slave that lets a host controller read and write an internal bank of registers of differing widths. The host frames each access with an active-low select. The first eight bits of every communication cycle form an instruction byte that names the direction and the target register. A data phase follows, and its length in bytes is the width of the register that was named. When that phase ends, the port again expects an instruction byte, even if the select stays low. Several accesses can therefore be chained inside one select window.

The serial clock, select and data input are resynchronised into the system clock domain. The port then acts on detected serial-clock edges. It takes incoming bits on rising edges and launches read data on falling edges, with the most significant bit first and the highest byte first. A static mode input decides how read data leaves the block. It goes either onto the shared data pin, under an output enable, or onto a separate output pin. Write data gathers in a shadow register and reaches the bank in one step, together with a one-cycle strobe for the register that changed.

Top module: `iframe_regport`

## Requirements
- R1: Instruction bit 7 selects the direction: 1 means read and 0 means write. Bits 4..0 give the register address, and bits 6..5 are ignored. With the default parameters, addresses 0, 1, 2 and 3 hold registers that are 1, 2, 4 and 6 bytes wide. Every other address is unmapped.
- R2: While select is low, instruction and write-data bits are taken on rising serial-clock edges. Each byte arrives most significant bit first.
- R3: A write changes the addressed register only after its final data bit. At that point the whole value is written in one step, and the matching bit of `wr_stb_o` pulses high for exactly one clock cycle. At most one strobe bit is high at any time.
- R4: The data phase carries exactly as many bytes as the addressed register is wide, highest byte first. The rising edges that follow it form a new instruction byte, even if select has stayed low.
- R5: Read data is launched on falling serial-clock edges. The first data bit is launched on the falling edge that follows the eighth rising edge. Bits go out most significant bit first and highest byte first.
- R6: When `wire3_i` is 1, read data goes out on `sdio_o`. `sdio_oe` is high only during the data phase of a read. `sdo_o` stays low.
- R7: When `wire3_i` is 0, read data goes out on `sdo_o`. `sdio_oe` stays low.
- R8: An unmapped address produces a zero-length data phase. Nothing is written and nothing is driven, and the next eight rising edges form a new instruction.
- R9: Raising select at any point abandons the cycle. A partial write is discarded, the output driver is released, and the bit and byte counts restart for the next frame.
- R10: The serial clock may idle either low or high between frames, and both give the same results.
- R11: After reset every register reads zero, no strobe is active, and neither output pin is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| wire3_i | input | 1 | 1: read data on the shared pin; 0: read data on `sdo_o` |
| csn_i | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Input side of the shared data pin |
| sdio_o | output | 1 | Output side of the shared data pin |
| sdio_oe | output | 1 | Drive enable for the shared data pin |
| sdo_o | output | 1 | Dedicated read-data output |
| wr_stb_o | output | NREG | One-cycle commit strobe, one bit per register |
| bank_o | output | NREG*MAXB*8 | Register contents; register i sits at bits [i*MAXB*8 +: MAXB*8], zero-extended |

## Verification
The assertions rely on the serial pins changing slowly compared with `clk`. Each serial-clock level must last for several system clocks, so that every edge is seen once after resynchronisation. The stimulus holds each serial-clock half period for eight system clocks. It changes the data pin only while the serial clock is low, and changes select only in stable serial-clock phases. Between frames it waits long enough for the synchronisers to settle. The stimulus also keeps `wire3_i` constant within a frame and never shortens a write except in the deliberate abort scenario.

// File: rtl/iframe_pkg.sv
package iframe_pkg;
   // width of one entry of the per-register length table
   localparam int LEN_W = 4;

   typedef enum logic {
      PH_INSTR = 1'b0,
      PH_DATA  = 1'b1
   } phase_e;
endpackage

// File: rtl/iframe_sync.sv
module iframe_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("iframe_sync needs at least two stages");
   end

   logic [STAGES-1:0][W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= {STAGES{RST_VAL}};
      end else begin
         pipe_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) begin
            pipe_q[s] <= pipe_q[s-1];
         end
      end
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/iframe_bank.sv
module iframe_bank
   import iframe_pkg::*;
#(
   parameter int                     ADDR_W    = 5,
   parameter int                     NREG      = 4,
   parameter int                     MAXB      = 6,
   parameter logic [NREG*LEN_W-1:0]  LEN_TABLE = {4'd6, 4'd4, 4'd2, 4'd1}
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we_i,
   input  logic [ADDR_W-1:0]      waddr_i,
   input  logic [MAXB*8-1:0]      wdata_i,
   input  logic [ADDR_W-1:0]      laddr_i,
   output logic [LEN_W-1:0]       len_o,
   output logic [MAXB*8-1:0]      rdata_o,
   output logic [NREG-1:0]        wr_stb_o,
   output logic [NREG*MAXB*8-1:0] bank_o
);
   localparam int DW = MAXB * 8;

   logic [DW-1:0] view [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam int            LEN_I  = int'(LEN_TABLE[i*LEN_W +: LEN_W]);
      localparam logic [DW-1:0] MASK_I = {DW{1'b1}} >> ((MAXB - LEN_I) * 8);

      if (LEN_I < 1 || LEN_I > MAXB) begin : g_bad_len
         $error("register length out of range");
      end

      logic [DW-1:0] val_q;
      logic          stb_q;
      logic          hit;

      assign hit = we_i && (waddr_i == ADDR_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= '0;
            stb_q <= 1'b0;
         end else begin
            stb_q <= hit;
            if (hit) val_q <= wdata_i & MASK_I;
         end
      end

      assign view[i]              = val_q;
      assign wr_stb_o[i]          = stb_q;
      assign bank_o[i*DW +: DW]   = val_q;
   end

   // length and value lookup; unmapped addresses report length zero
   always_comb begin
      len_o   = '0;
      rdata_o = '0;
      for (int i = 0; i < NREG; i++) begin
         if (laddr_i == ADDR_W'(i)) begin
            len_o   = LEN_TABLE[i*LEN_W +: LEN_W];
            rdata_o = view[i];
         end
      end
   end

   AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_stb_o)); // R3
endmodule

// File: rtl/iframe_ctrl.sv
module iframe_ctrl
   import iframe_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int MAXB   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              sdi_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [MAXB*8-1:0] rdata_i,
   output logic [ADDR_W-1:0] laddr_o,
   output logic [ADDR_W-1:0] waddr_o,
   output logic              we_o,
   output logic [MAXB*8-1:0] wdata_o,
   output logic              sdo_o,
   output logic              oe_o
);
   localparam int DW = MAXB * 8;

   phase_e            phase_q;
   logic              rd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  byte_q;
   logic [2:0]        bit_q;
   logic [DW-1:0]     sh_q;
   logic [DW-1:0]     sh_nxt;
   logic [DW-1:0]     out_sr_q;
   logic [DW-1:0]     wdata_q;
   logic              we_q;
   logic              sdo_q;
   logic              oe_q;

   assign sh_nxt  = {sh_q[DW-2:0], sdi_i};
   // lookup address is only consumed on the eighth instruction bit
   assign laddr_o = sh_nxt[ADDR_W-1:0];
   assign waddr_o = addr_q;
   assign we_o    = we_q;
   assign wdata_o = wdata_q;
   assign sdo_o   = sdo_q;
   assign oe_o    = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_INSTR;
         rd_q     <= 1'b0;
         addr_q   <= '0;
         len_q    <= '0;
         byte_q   <= '0;
         bit_q    <= '0;
         sh_q     <= '0;
         out_sr_q <= '0;
         wdata_q  <= '0;
         we_q     <= 1'b0;
         sdo_q    <= 1'b0;
         oe_q     <= 1'b0;
      end else begin
         we_q <= 1'b0;
         if (csn_i) begin
            phase_q <= PH_INSTR;
            bit_q   <= '0;
            byte_q  <= '0;
            oe_q    <= 1'b0;
            sdo_q   <= 1'b0;
         end else if (rise_i) begin
            sh_q  <= sh_nxt;
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
               if (phase_q == PH_INSTR) begin
                  rd_q     <= sh_nxt[7];
                  addr_q   <= sh_nxt[ADDR_W-1:0];
                  len_q    <= len_i;
                  byte_q   <= '0;
                  sh_q     <= '0;
                  out_sr_q <= rdata_i << ((MAXB - int'(len_i)) * 8);
                  if (len_i != '0) phase_q <= PH_DATA;
               end else begin
                  byte_q <= byte_q + 1'b1;
                  if (byte_q == len_q - 1'b1) begin
                     phase_q <= PH_INSTR;
                     byte_q  <= '0;
                     oe_q    <= 1'b0;
                     if (!rd_q) begin
                        we_q    <= 1'b1;
                        wdata_q <= sh_nxt;
                     end
                  end
               end
            end
         end else if (fall_i && phase_q == PH_DATA && rd_q) begin
            sdo_q    <= out_sr_q[DW-1];
            out_sr_q <= out_sr_q << 1;
            oe_q     <= 1'b1;
         end
      end
   end

   AST_DESEL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      csn_i |=> (phase_q == PH_INSTR && bit_q == 3'd0 && !oe_q)); // R9
   AST_SHIFT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise_i && !csn_i) |=> $stable(bit_q)); // R2
   AST_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall_i && !csn_i) |=> $stable(sdo_q)); // R5
   AST_COMMIT_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |-> $past(rise_i)); // R3
   AST_DATA_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DATA) |-> (len_q != '0)); // R8
   AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> rd_q); // R6
endmodule

// File: rtl/iframe_regport.sv
module iframe_regport
   import iframe_pkg::*;
#(
   parameter int                     ADDR_W      = 5,
   parameter int                     NREG        = 4,
   parameter int                     MAXB        = 6,
   parameter logic [NREG*LEN_W-1:0]  LEN_TABLE   = {4'd6, 4'd4, 4'd2, 4'd1},
   parameter int                     SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wire3_i,
   input  logic                   csn_i,
   input  logic                   sclk_i,
   input  logic                   sdio_i,
   output logic                   sdio_o,
   output logic                   sdio_oe,
   output logic                   sdo_o,
   output logic [NREG-1:0]        wr_stb_o,
   output logic [NREG*MAXB*8-1:0] bank_o
);
   localparam int DW = MAXB * 8;

   if (ADDR_W < 1 || ADDR_W > 7) begin : g_bad_addr
      $error("address field must fit below the direction bit");
   end
   if (NREG < 1 || NREG > (1 << ADDR_W)) begin : g_bad_nreg
      $error("register count does not fit the address field");
   end
   if (MAXB < 1 || MAXB >= (1 << LEN_W)) begin : g_bad_maxb
      $error("maximum register width out of range");
   end

   logic [2:0]        pins_s;
   logic              csn_s, sclk_s, sdi_s, sclk_q;
   logic              rise, fall;
   logic [LEN_W-1:0]  len;
   logic [DW-1:0]     rdata, wdata;
   logic [ADDR_W-1:0] laddr, waddr;
   logic              we, sdo, oe;

   iframe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({csn_i, sclk_i, sdio_i}),
      .q_o   (pins_s)
   );
   assign {csn_s, sclk_s, sdi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   assign rise = !csn_s &&  sclk_s && !sclk_q;
   assign fall = !csn_s && !sclk_s &&  sclk_q;

   iframe_ctrl #(.ADDR_W(ADDR_W), .MAXB(MAXB)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .csn_i   (csn_s),
      .rise_i  (rise),
      .fall_i  (fall),
      .sdi_i   (sdi_s),
      .len_i   (len),
      .rdata_i (rdata),
      .laddr_o (laddr),
      .waddr_o (waddr),
      .we_o    (we),
      .wdata_o (wdata),
      .sdo_o   (sdo),
      .oe_o    (oe)
   );

   iframe_bank #(.ADDR_W(ADDR_W), .NREG(NREG), .MAXB(MAXB), .LEN_TABLE(LEN_TABLE)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (we),
      .waddr_i  (waddr),
      .wdata_i  (wdata),
      .laddr_i  (laddr),
      .len_o    (len),
      .rdata_o  (rdata),
      .wr_stb_o (wr_stb_o),
      .bank_o   (bank_o)
   );

   assign sdio_o  = sdo;
   assign sdio_oe = wire3_i & oe;
   assign sdo_o   = !wire3_i & oe & sdo;

   AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_stb_o) |-> $past(!csn_s, 2)); // R3
endmodule

// File: tb/iframe_regport_test.sv
`timescale 1ns/1ps
module iframe_regport_test;
   localparam int HALF = 40;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wire3_i = 1'b1;
   logic         csn_i = 1'b1;
   logic         sclk_i = 1'b0;
   logic         sdio_i = 1'b0;
   logic         sdio_o, sdio_oe, sdo_o;
   logic [3:0]   wr_stb_o;
   logic [191:0] bank_o;

   int  checks = 0;
   int  errors = 0;
   int  stb_cnt = 0;
   logic [3:0] last_stb = '0;
   bit  done = 0;
   bit  cpol_hi = 0;

   iframe_regport uut (
      .clk(clk), .rst_n(rst_n), .wire3_i(wire3_i), .csn_i(csn_i),
      .sclk_i(sclk_i), .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
      .sdo_o(sdo_o), .wr_stb_o(wr_stb_o), .bank_o(bank_o)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      if (|wr_stb_o) begin
         stb_cnt  <= stb_cnt + 1;
         last_stb <= wr_stb_o;
      end
   end

   function automatic logic [47:0] regv(input int i);
      return bank_o[i*48 +: 48];
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic frame_on(input bit hi);
      cpol_hi = hi;
      sclk_i  = hi;
      #HALF;
      csn_i = 1'b0;
      #HALF;
   endtask

   task automatic frame_off();
      if (!cpol_hi) begin
         sclk_i = 1'b0;
         #HALF;
      end
      csn_i = 1'b1;
      #(HALF*3);
   endtask

   // one instruction plus nb data bytes; stop_at >= 0 cuts it short
   task automatic run_cycle(input logic [7:0] ins, input int nb, input logic [47:0] wd,
                            input int stop_at, output logic [47:0] rd,
                            output int oe_ins, output int oe_dat);
      rd = '0; oe_ins = 0; oe_dat = 0;
      for (int b = 0; b < 8 + nb*8; b++) begin
         logic bitv;
         if (stop_at >= 0 && b == stop_at) return;
         bitv   = (b < 8) ? ins[7-b] : wd[nb*8-1-(b-8)];
         sclk_i = 1'b0;
         sdio_i = bitv;
         #HALF;
         if (b < 8) oe_ins += int'(sdio_oe);
         else begin
            oe_dat += int'(sdio_oe);
            rd = {rd[46:0], (wire3_i ? sdio_o : sdo_o)};
         end
         sclk_i = 1'b1;
         #HALF;
      end
   endtask

   task automatic do_write(input bit hi, input logic [7:0] ins, input int nb, input logic [47:0] v);
      logic [47:0] rd; int oi, od;
      frame_on(hi);
      run_cycle(ins, nb, v, -1, rd, oi, od);
      frame_off();
   endtask

   task automatic do_read(input bit hi, input logic [7:0] ins, input int nb,
                          output logic [47:0] rd, output int oi, output int od);
      frame_on(hi);
      run_cycle(ins, nb, '0, -1, rd, oi, od);
      frame_off();
   endtask

   task automatic test_reset();
      for (int i = 0; i < 4; i++) chk("R11", "register after reset", regv(i), 48'h0);
      chk("R11", "strobe after reset", {44'h0, wr_stb_o}, 48'h0);
      chk("R11", "sdio_oe after reset", {47'h0, sdio_oe}, 48'h0);
      chk("R11", "sdo_o after reset", {47'h0, sdo_o}, 48'h0);
   endtask

   task automatic test_write_read_3w();
      logic [47:0] rd; int oi, od, s0;
      wire3_i = 1'b1;
      s0 = stb_cnt;
      do_write(0, 8'h02, 4, 48'hDEADBEEF);
      chk("R3", "reg2 after write", regv(2), 48'hDEADBEEF);
      chk("R3", "one strobe per write", 48'(stb_cnt - s0), 48'd1);
      chk("R1", "strobe bit for reg2", {44'h0, last_stb}, 48'h4);
      do_read(0, 8'h82, 4, rd, oi, od);
      chk("R5", "reg2 read value", rd, 48'hDEADBEEF);
      chk("R6", "no drive during instruction", 48'(oi), 48'd0);
      chk("R6", "drive during all data bits", 48'(od), 48'd32);
      chk("R6", "released after frame", {47'h0, sdio_oe}, 48'h0);
   endtask

   task automatic test_wide_cpol_high();
      logic [47:0] rd; int oi, od;
      do_write(1, 8'h03, 6, 48'hA1B2C3D4E5F6);
      chk("R10", "reg3 written with high idle clock", regv(3), 48'hA1B2C3D4E5F6);
      do_read(1, 8'h83, 6, rd, oi, od);
      chk("R4", "six-byte read with high idle clock", rd, 48'hA1B2C3D4E5F6);
      chk("R10", "drive count with high idle clock", 48'(od), 48'd48);
   endtask

   task automatic test_byte_reg();
      do_write(0, 8'h00, 1, 48'h96);
      chk("R1", "reg0 one byte", regv(0), 48'h96);
      chk("R1", "reg2 untouched by reg0 write", regv(2), 48'hDEADBEEF);
   endtask

   task automatic test_back_to_back();
      logic [47:0] rd; int oi, od;
      frame_on(0);
      run_cycle(8'h01, 2, 48'h5A3C, -1, rd, oi, od);
      run_cycle(8'h81, 2, '0, -1, rd, oi, od);
      frame_off();
      chk("R4", "reg1 written in chained cycle", regv(1), 48'h5A3C);
      chk("R4", "chained read after write", rd, 48'h5A3C);
      chk("R4", "no drive in chained instruction", 48'(oi), 48'd0);
   endtask

   task automatic test_unmapped();
      logic [47:0] rd, r0, r1, r2, r3; int oi, od, s0;
      r0 = regv(0); r1 = regv(1); r2 = regv(2); r3 = regv(3);
      s0 = stb_cnt;
      frame_on(0);
      run_cycle(8'h05, 0, '0, -1, rd, oi, od);
      run_cycle(8'h81, 2, '0, -1, rd, oi, od);
      frame_off();
      chk("R8", "instruction after unmapped address", rd, 48'h5A3C);
      chk("R8", "no drive after unmapped", 48'(oi), 48'd0);
      chk("R8", "no strobe for unmapped", 48'(stb_cnt - s0), 48'd0);
      chk("R8", "bank unchanged", {regv(0) ^ r0} | {regv(1) ^ r1} | {regv(2) ^ r2} | {regv(3) ^ r3}, 48'h0);
   endtask

   task automatic test_ignored_bits();
      do_write(0, 8'h62, 4, 48'h01234567);
      chk("R1", "bits 6..5 ignored, reg2 written", regv(2), 48'h01234567);
   endtask

   task automatic test_abort();
      logic [47:0] rd; int oi, od, s0;
      wire3_i = 1'b1;
      s0 = stb_cnt;
      frame_on(0);
      run_cycle(8'h03, 6, 48'h111111111111, 24, rd, oi, od);
      frame_off();
      chk("R9", "partial write discarded", regv(3), 48'hA1B2C3D4E5F6);
      chk("R9", "no strobe on aborted write", 48'(stb_cnt - s0), 48'd0);
      frame_on(0);
      run_cycle(8'h83, 6, '0, 12, rd, oi, od);
      #(HALF/2);
      chk("R9", "driving before abort", {47'h0, sdio_oe}, 48'h1);
      frame_off();
      chk("R9", "driver released on abort", {47'h0, sdio_oe}, 48'h0);
      do_write(0, 8'h00, 1, 48'h3C);
      chk("R9", "counters restart after abort", regv(0), 48'h3C);
   endtask

   task automatic test_4wire();
      logic [47:0] rd; int oi, od;
      wire3_i = 1'b0;
      do_read(0, 8'h82, 4, rd, oi, od);
      chk("R7", "read on dedicated output", rd, 48'h01234567);
      chk("R7", "shared pin never driven", 48'(oi + od), 48'd0);
      chk("R7", "dedicated output low after frame", {47'h0, sdo_o}, 48'h0);
      wire3_i = 1'b1;
   endtask

   initial begin
      #100;
      rst_n = 1'b1;
      #100;
      test_reset();
      test_write_read_3w();
      test_wide_cpol_high();
      test_byte_reg();
      test_back_to_back();
      test_unmapped();
      test_ignored_bits();
      test_abort();
      test_4wire();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule